// File: doc/BRIEF.md
# Debug address watchpoint unit

This block watches a processor's memory traffic for up to four programmed addresses. Software loads each watch slot with an address and sets a shared control word. In that word, each slot has an access-type selector, a length selector and two enable bits. Every cycle the block compares the offered access against all slots. The access is described by its byte address, its kind (instruction fetch, data read or data write) and its size in bytes.

When an enabled slot's byte window overlaps the access and the access kind is one that slot accepts, the block does two things. It latches the slot's flag in a sticky status word, and it raises a one-cycle trap pulse on the following cycle. Two external cause inputs also latch their own status flags and raise the same pulse: one for single-step and one for a context (task) switch. A context switch also drops every slot's local enable, and the global enables survive it.

Registers are reached through a plain indexed port. Writes take effect at the clock edge. Reads are combinational from the current register contents.

The access input has a valid/ready pair. The block never applies back-pressure: ready is held high, so every cycle with valid high is compared. A cycle with valid low is never compared.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset every register reads zero and trap_pulse is low.
- R2: Register index 0 to 3 selects watch address slots 0 to 3, index 6 selects status and index 7 selects control. Indices 4 and 5 read zero and ignore writes. Reads show the register value after all earlier writes.
- R3: Control bits 15:10 always read zero, and writes to them are ignored. Bits 9:8 are plain storage.
- R4: Slot n is active when control bit 2n (local enable) or bit 2n+1 (global enable) is set. An inactive slot never flags.
- R5: Control bits 16+4n+1 : 16+4n select slot n's access kind. 00 matches fetches only, 01 matches writes only, 11 matches reads or writes, and 10 never matches. The access kind input codes are 00 fetch, 01 read and 10 write.
- R6: Control bits 16+4n+3 : 16+4n+2 select slot n's window length. 00 is 1 byte, 01 is 2 bytes, 11 is 4 bytes and 10 is 8 bytes. The window starts at the slot address rounded down to a multiple of that length.
- R7: The access covers 2^acc_size bytes starting at acc_addr. A match needs this byte range to overlap the slot window.
- R8: A match sets status bit n at the next edge and raises trap_pulse for exactly the cycle after the access. Status bits stay set until software writes status.
- R9: step_evt sets status bit 14 and tswitch_evt sets status bit 15. Each of them raises trap_pulse in the next cycle.
- R10: tswitch_evt clears all local enable bits (mask 0x55) at the next edge, and this clear also overrides a control write made in the same cycle. Global enables and all other fields are kept.
- R11: A software write to status replaces it with the written value. Hardware flags set in the same cycle are ORed on top of the written value.
- R12: acc_ready is always high. A cycle with acc_valid low causes no match.
- R13: Only status bits 3:0, 14 and 15 can be set. All other status bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offered this cycle |
| acc_ready | output | 1 | Always high; the block never stalls |
| acc_addr | input | AW | Access start byte address |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write |
| acc_size | input | 2 | log2 of access byte count |
| step_evt | input | 1 | Single-step cause |
| tswitch_evt | input | 1 | Task-switch cause |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| trap_pulse | output | 1 | One-cycle debug trap |

## Verification
A corrupted slot window or access-kind decode shows up as a wrong trap_pulse value one cycle after the offending access. The same fault appears as a wrong flag when status is read in that same cycle. A lost local-enable clear is visible on the very next fetch to that slot, because that fetch still traps when it should not. The status word is sticky, so a flag that was set by mistake stays readable until software rewrites it, and a flag that drops out early is caught on any later status read.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

  localparam int unsigned DW        = 32;
  localparam logic [2:0]  IDX_STAT  = 3'd6;
  localparam logic [2:0]  IDX_CTL   = 3'd7;
  localparam int unsigned STEP_BIT  = 14;
  localparam int unsigned SWTCH_BIT = 15;
  localparam int unsigned CFG_LSB   = 16;
  localparam int unsigned CFG_W     = 4;
  localparam logic [DW-1:0] CTL_RSVD = 32'h0000_FC00;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    RW_EXEC = 2'b00,
    RW_WR   = 2'b01,
    RW_IO   = 2'b10,
    RW_RDWR = 2'b11
  } rw_sel_e;

  typedef enum logic [1:0] {
    LEN_1 = 2'b00,
    LEN_2 = 2'b01,
    LEN_8 = 2'b10,
    LEN_4 = 2'b11
  } len_sel_e;

  typedef struct packed {
    len_sel_e len;
    rw_sel_e  rw;
  } slot_cfg_t;

  // bits cleared by a task switch: one local enable per slot
  function automatic logic [DW-1:0] local_en_mask(int unsigned nslot);
    logic [DW-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nslot; i++) m[2*i] = 1'b1;
    return m;
  endfunction

  // bits of the status word that hardware may set
  function automatic logic [DW-1:0] stat_valid_mask(int unsigned nslot);
    logic [DW-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nslot; i++) m[i] = 1'b1;
    m[STEP_BIT]  = 1'b1;
    m[SWTCH_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [3:0] window_bytes(len_sel_e l);
    case (l)
      LEN_1:   return 4'd1;
      LEN_2:   return 4'd2;
      LEN_4:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/dbgw_slot_cmp.sv
module dbgw_slot_cmp
  import dbgw_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          enable,
  input  slot_cfg_t     cfg,
  input  logic [AW-1:0] watch_addr,
  input  logic          acc_valid,
  input  acc_kind_e     acc_kind,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  output logic          hit
);

  logic [3:0]  win_len;
  logic [3:0]  acc_span;
  logic [AW:0] win_lo, win_hi, acc_lo, acc_hi;
  logic        kind_ok;
  logic        overlap;

  always_comb begin
    win_len  = window_bytes(cfg.len);
    acc_span = (4'd1 << acc_size) - 4'd1;
    win_lo   = {1'b0, watch_addr & ~{{(AW-4){1'b0}}, win_len - 4'd1}};
    win_hi   = win_lo + {{(AW-3){1'b0}}, win_len - 4'd1};
    acc_lo   = {1'b0, acc_addr};
    acc_hi   = acc_lo + {{(AW-3){1'b0}}, acc_span};
    overlap  = (acc_lo <= win_hi) && (win_lo <= acc_hi);
  end

  always_comb begin
    case (cfg.rw)
      RW_EXEC: kind_ok = (acc_kind == ACC_FETCH);
      RW_WR:   kind_ok = (acc_kind == ACC_WRITE);
      RW_RDWR: kind_ok = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
      default: kind_ok = 1'b0;
    endcase
  end

  assign hit = acc_valid && enable && kind_ok && overlap;

endmodule

// File: rtl/dbgw_regfile.sv
module dbgw_regfile
  import dbgw_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NSLOT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [2:0]                reg_idx,
  input  logic [DW-1:0]             reg_wdata,
  input  logic [NSLOT-1:0]          hit_vec,
  input  logic                      step_evt,
  input  logic                      tswitch_evt,
  output logic [DW-1:0]             reg_rdata,
  output logic [NSLOT-1:0][AW-1:0]  watch_addr,
  output logic [2*NSLOT-1:0]        en_bits,
  output slot_cfg_t [NSLOT-1:0]     cfg_vec,
  output logic [DW-1:0]             ctl_o,
  output logic [DW-1:0]             stat_o
);

  localparam logic [DW-1:0] LOC_MASK  = local_en_mask(NSLOT);
  localparam logic [DW-1:0] STAT_MASK = stat_valid_mask(NSLOT);

  logic [NSLOT-1:0][AW-1:0] addr_q;
  logic [DW-1:0] ctl_q, ctl_n;
  logic [DW-1:0] stat_q, stat_n;
  logic [DW-1:0] stat_set;

  for (genvar n = 0; n < NSLOT; n++) begin : g_addr
    always_ff @(posedge clk) begin
      if (!rst_n)
        addr_q[n] <= '0;
      else if (reg_wr && reg_idx == 3'(n))
        addr_q[n] <= reg_wdata[AW-1:0];
    end
    assign cfg_vec[n] = slot_cfg_t'(ctl_q[CFG_LSB + CFG_W*n +: CFG_W]);
  end

  always_comb begin
    stat_set = '0;
    stat_set[NSLOT-1:0]  = hit_vec;
    stat_set[STEP_BIT]   = step_evt;
    stat_set[SWTCH_BIT]  = tswitch_evt;

    stat_n = stat_q;
    if (reg_wr && reg_idx == IDX_STAT) stat_n = reg_wdata & STAT_MASK;
    stat_n = stat_n | stat_set;

    ctl_n = ctl_q;
    if (reg_wr && reg_idx == IDX_CTL) ctl_n = reg_wdata & ~CTL_RSVD;
    if (tswitch_evt) ctl_n = ctl_n & ~LOC_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      stat_q <= '0;
    end else begin
      ctl_q  <= ctl_n;
      stat_q <= stat_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NSLOT; n++)
      if (reg_idx == 3'(n)) reg_rdata = DW'(addr_q[n]);
    if (reg_idx == IDX_STAT) reg_rdata = stat_q;
    if (reg_idx == IDX_CTL)  reg_rdata = ctl_q;
  end

  assign watch_addr = addr_q;
  assign en_bits    = ctl_q[2*NSLOT-1:0];
  assign ctl_o      = ctl_q;
  assign stat_o     = stat_q;

endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbgw_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NSLOT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_kind,
  input  logic [1:0]    acc_size,
  input  logic          step_evt,
  input  logic          tswitch_evt,
  input  logic          reg_wr,
  input  logic [2:0]    reg_idx,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          trap_pulse
);

  logic [NSLOT-1:0][AW-1:0] watch_addr;
  logic [2*NSLOT-1:0]       en_bits;
  slot_cfg_t [NSLOT-1:0]    cfg_vec;
  logic [NSLOT-1:0]         hit_vec;
  logic [DW-1:0]            ctl_w, stat_w;
  logic                     trap_q;

  dbgw_regfile #(.AW(AW), .NSLOT(NSLOT)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_idx     (reg_idx),
    .reg_wdata   (reg_wdata),
    .hit_vec     (hit_vec),
    .step_evt    (step_evt),
    .tswitch_evt (tswitch_evt),
    .reg_rdata   (reg_rdata),
    .watch_addr  (watch_addr),
    .en_bits     (en_bits),
    .cfg_vec     (cfg_vec),
    .ctl_o       (ctl_w),
    .stat_o      (stat_w)
  );

  for (genvar n = 0; n < NSLOT; n++) begin : g_slot
    dbgw_slot_cmp #(.AW(AW)) u_cmp (
      .enable     (en_bits[2*n] | en_bits[2*n+1]),
      .cfg        (cfg_vec[n]),
      .watch_addr (watch_addr[n]),
      .acc_valid  (acc_valid),
      .acc_kind   (acc_kind_e'(acc_kind)),
      .acc_addr   (acc_addr),
      .acc_size   (acc_size),
      .hit        (hit_vec[n])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= (|hit_vec) | step_evt | tswitch_evt;
  end

  assign trap_pulse = trap_q;
  assign acc_ready  = 1'b1;

endmodule

// File: rtl/dbgw_checker.sv
module dbgw_checker
  import dbgw_pkg::*;
#(
  parameter int unsigned NSLOT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          step_evt,
  input logic          tswitch_evt,
  input logic          reg_wr,
  input logic [2:0]    reg_idx,
  input logic          trap_pulse,
  input logic [DW-1:0] ctl,
  input logic [DW-1:0] stat
);

  localparam logic [DW-1:0] LOC_MASK  = local_en_mask(NSLOT);
  localparam logic [DW-1:0] STAT_MASK = stat_valid_mask(NSLOT);

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl & CTL_RSVD) == '0);

  assert_local_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tswitch_evt |=> (ctl & LOC_MASK) == '0);

  assert_step_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (stat[STEP_BIT] && trap_pulse));

  assert_switch_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tswitch_evt |=> (stat[SWTCH_BIT] && trap_pulse));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_idx == IDX_STAT) |=> ((stat & $past(stat)) == $past(stat)));

  assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !step_evt && !tswitch_evt) |=> !trap_pulse);

  assert_stat_bits_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~STAT_MASK) == '0);

endmodule

bind dbg_watch_unit dbgw_checker #(.NSLOT(NSLOT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .step_evt    (step_evt),
  .tswitch_evt (tswitch_evt),
  .reg_wr      (reg_wr),
  .reg_idx     (reg_idx),
  .trap_pulse  (trap_pulse),
  .ctl         (ctl_w),
  .stat        (stat_w)
);

// File: tb/test_dbg_watch_unit.sv
module test_dbg_watch_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = 2'b00;
  logic [1:0]  acc_size = 2'b00;
  logic        step_evt = 1'b0;
  logic        tswitch_evt = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        trap_pulse;

  always #2 clk = ~clk;  // 250 MHz

  dbg_watch_unit i_dbg_watch_unit (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_size(acc_size),
    .step_evt(step_evt), .tswitch_evt(tswitch_evt),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trap_pulse(trap_pulse)
  );

  typedef struct {
    bit          trap;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // independent reference state
  logic [31:0] m_addr [4];
  logic [31:0] m_ctl  = '0;
  logic [31:0] m_stat = '0;

  localparam bit [1:0] K_F = 2'b00, K_R = 2'b01, K_W = 2'b10;

  function automatic bit ref_hit(int n, bit v, logic [1:0] k, logic [31:0] a, logic [1:0] sz);
    logic [1:0] rw;
    logic [1:0] ln;
    longint len, base, b;
    bit     kind_ok;
    if (!v) return 0;
    if (!(m_ctl[2*n] || m_ctl[2*n+1])) return 0;
    rw = m_ctl[16+4*n +: 2];
    ln = m_ctl[18+4*n +: 2];
    case (rw)
      2'b00:   kind_ok = (k == K_F);
      2'b01:   kind_ok = (k == K_W);
      2'b11:   kind_ok = (k == K_R) || (k == K_W);
      default: kind_ok = 0;
    endcase
    if (!kind_ok) return 0;
    len  = (ln == 2'b00) ? 1 : (ln == 2'b01) ? 2 : (ln == 2'b11) ? 4 : 8;
    base = longint'(m_addr[n]) - (longint'(m_addr[n]) % len);
    for (int i = 0; i < (1 << sz); i++) begin
      b = longint'(a) + i;
      if (b >= base && b < base + len) return 1;
    end
    return 0;
  endfunction

  function automatic logic [31:0] ref_read(logic [2:0] idx);
    if (idx < 4)  return m_addr[idx[1:0]];
    if (idx == 6) return m_stat;
    if (idx == 7) return m_ctl;
    return '0;
  endfunction

  // driver: one cycle of stimulus, expectation pushed for the monitor
  task automatic cyc(input bit v, input logic [1:0] k, input logic [31:0] a,
                     input logic [1:0] sz, input bit st, input bit ts,
                     input bit wr, input logic [2:0] idx, input logic [31:0] wd,
                     input string tag);
    logic [3:0] hits;
    exp_t e;
    @(negedge clk);
    acc_valid = v; acc_kind = k; acc_addr = a; acc_size = sz;
    step_evt = st; tswitch_evt = ts;
    reg_wr = wr; reg_idx = idx; reg_wdata = wd;
    for (int n = 0; n < 4; n++) hits[n] = ref_hit(n, v, k, a, sz);
    if (wr && idx == 6) m_stat = wd & 32'h0000_C00F;
    m_stat = m_stat | {16'h0, ts, st, 10'h0, hits};
    if (wr && idx == 7) m_ctl = wd & ~32'h0000_FC00;
    if (ts) m_ctl = m_ctl & ~32'h0000_0055;
    if (wr && idx < 4) m_addr[idx[1:0]] = wd;
    e.trap = (|hits) | st | ts;
    e.rd   = ref_read(idx);
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic idle(input logic [2:0] idx, input string tag);
    cyc(0, K_F, 32'h0, 2'd0, 0, 0, 0, idx, 32'h0, tag);
  endtask

  task automatic acc(input logic [1:0] k, input logic [31:0] a, input logic [1:0] sz,
                     input string tag);
    cyc(1, k, a, sz, 0, 0, 0, 3'd6, 32'h0, tag);
  endtask

  task automatic wreg(input logic [2:0] idx, input logic [31:0] wd, input string tag);
    cyc(0, K_F, 32'h0, 2'd0, 0, 0, 1, idx, wd, tag);
  endtask

  // monitor: compares after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        e = q.pop_front();
        n_vec++;
        if (trap_pulse !== e.trap || reg_rdata !== e.rd) begin
          n_bad++;
          $display("FAIL %s: trap=%0b rdata=%08h expected trap=%0b rdata=%08h",
                   e.tag, trap_pulse, reg_rdata, e.trap, e.rd);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_addr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) idle(3'(i), "R1 reset value");

    wreg(3'd0, 32'h0000_1000, "R2 slot0 address");
    wreg(3'd1, 32'h0000_2003, "R2 slot1 address");
    wreg(3'd2, 32'h0000_3005, "R2 slot2 address");
    wreg(3'd3, 32'h0000_4000, "R2 slot3 address");
    wreg(3'd4, 32'hDEAD_BEEF, "R2 index 4 ignored");
    idle(3'd5, "R2 index 5 reads zero");
    wreg(3'd7, 32'h2B0D_FDE6, "R3 reserved bits dropped");

    acc(K_W, 32'h0000_1002, 2'd0, "R6 4-byte window write hit");
    idle(3'd6, "R8 sticky flag, single pulse");
    wreg(3'd6, 32'h0, "R11 status cleared");
    acc(K_R, 32'h0000_1002, 2'd0, "R5 read ignored by write-only slot");
    acc(K_W, 32'h0000_1004, 2'd0, "R6 past window end");
    acc(K_W, 32'h0000_0FFE, 2'd2, "R7 wide access overlaps start");
    acc(K_W, 32'h0000_0FFC, 2'd1, "R7 access just below window");
    acc(K_F, 32'h0000_2003, 2'd0, "R5 fetch slot, local enable R4");
    acc(K_F, 32'h0000_2002, 2'd1, "R7 two-byte fetch overlap");
    acc(K_R, 32'h0000_2003, 2'd0, "R5 read on fetch slot");
    wreg(3'd6, 32'h0, "R11 status cleared");
    acc(K_R, 32'h0000_3007, 2'd0, "R6 8-byte window read hit");
    acc(K_W, 32'h0000_3008, 2'd0, "R6 8-byte window end");
    acc(K_F, 32'h0000_3000, 2'd0, "R5 fetch on read/write slot");
    acc(K_W, 32'h0000_4000, 2'd0, "R5 code 10 never matches");
    cyc(0, K_W, 32'h0000_1002, 2'd0, 0, 0, 0, 3'd6, 32'h0, "R12 valid low no match");
    cyc(0, K_F, 32'h0, 2'd0, 1, 0, 0, 3'd6, 32'h0, "R9 single step");
    cyc(1, K_W, 32'h0000_1003, 2'd0, 0, 0, 1, 3'd6, 32'h0, "R11 hardware set wins");
    wreg(3'd6, 32'hFFFF_FFFF, "R13 unused status bits");
    wreg(3'd6, 32'h0, "R11 status cleared");
    cyc(0, K_F, 32'h0, 2'd0, 0, 1, 0, 3'd7, 32'h0, "R10 local enables cleared");
    idle(3'd6, "R9 task switch flag");
    acc(K_F, 32'h0000_2003, 2'd0, "R10 local-only slot now off");
    acc(K_W, 32'h0000_1000, 2'd0, "R10 global slot still on");
    wreg(3'd7, 32'h0, "R4 all disabled");
    acc(K_W, 32'h0000_1000, 2'd0, "R4 disabled slot no hit");
    cyc(0, K_F, 32'h0, 2'd0, 0, 1, 1, 3'd7, 32'h0000_00FF, "R10 clear beats write");
    idle(3'd6, "R8 idle pulse low");
    idle(3'd7, "R3 final control");

    @(posedge clk); #1;
    n_vec++;
    if (acc_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R12 acc_ready: got %0b expected 1", acc_ready);
    end
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule